// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus port of a parallel NOR-style flash model and turns the stream of single-cycle write strobes into a small set of internal operations. It recognises the two-write unlock pair, the erase set-up prefix, the chip-erase and sector-erase commands, the normal program sequence, and a bypass mode in which program writes need no unlock pair. Each recognised operation produces a one-cycle start pulse to the embedded-operation engine. The pulse comes with the captured address, and for a program it also carries the data byte.

The engine reports back through a busy input. While busy is high, the decoder drops every write and holds its position in the sequence. Any cycle that breaks a normal-mode sequence sends the decoder back to read-array mode. In bypass mode, writes that are not allowed there are dropped and the decoder stays in bypass. An asserted reset returns the decoder to read-array mode at once. Reset is asserted asynchronously and released on the clock.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `read_mode` is 1, `bypass_mode` is 0 and all three start pulses are 0.
- R2: The six accepted writes AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh and 10h at 555h raise `start_chip` in the cycle after the sixth write, and the decoder is back in read-array mode. Only the low `CMD_AW` address bits are compared.
- R3: The same five-write prefix followed by 30h at any address raises `start_sect`, and `op_addr` holds the full address of that sixth write.
- R4: AAh at 555h, 55h at 2AAh and A0h at 555h, followed by a write of any address and data, raise `start_prog` in the cycle after that write. `op_addr` and `op_data` then hold that write's address and data, and the decoder is back in read-array mode.
- R5: The unlock pair followed by 20h at 555h puts the decoder in bypass mode: `bypass_mode` is 1 and `read_mode` is 0.
- R6: In bypass mode, A0h at any address followed by one write of any address and data raises `start_prog` with that address and data, and the decoder stays in bypass mode.
- R7: In bypass mode, every write other than A0h or 90h is dropped. A write other than 00h after 90h is also dropped. After a dropped write no start pulse follows and `bypass_mode` stays 1.
- R8: In bypass mode, 90h followed by 00h, both at any address, returns the decoder to read-array mode.
- R9: In normal mode, a write whose address or data does not match the expected step of a sequence returns the decoder to read-array mode with no start pulse.
- R10: Writes presented while `eng_busy` is 1 are dropped. No start pulse follows, and the sequence position is unchanged once busy falls.
- R11: Each start pulse lasts exactly one cycle, and no two start pulses are high together.
- R12: Asserting reset in the middle of a sequence or in bypass mode returns the decoder to read-array mode at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Data byte of the write |
| eng_busy | input | 1 | Embedded-operation engine is running |
| start_prog | output | 1 | One-cycle program start |
| start_chip | output | 1 | One-cycle chip-erase start |
| start_sect | output | 1 | One-cycle sector-erase start |
| op_addr | output | ADDR_W | Address captured with the last start |
| op_data | output | 8 | Data captured with the last program start |
| read_mode | output | 1 | Decoder is idle in read-array mode |
| bypass_mode | output | 1 | Decoder is in bypass mode |

## Verification
The bench builds the decoder with its defaults: a 20-bit address, of which the low 11 bits are compared against the unlock addresses. The upper nine bits are therefore free to vary in the stimulus. Unlock and command writes carry non-zero upper bits, which shows that only the low field is decoded. Sector and program addresses span the whole word, so the captured `op_addr` is checked over all 20 bits.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_ESETUP,
    ST_EUNL1,
    ST_EUNL2,
    ST_PGM,
    ST_BYP,
    ST_BYP_PGM,
    ST_BYP_EXIT
  } seq_state_e;

  typedef enum logic [1:0] {
    FIRE_NONE,
    FIRE_PGM,
    FIRE_CHIP,
    FIRE_SECT
  } fire_e;

  localparam logic [7:0] KEY_A = 8'hAA;
  localparam logic [7:0] KEY_B = 8'h55;

  // command code table, index 0 in the low byte
  localparam int N_CMD   = 7;
  localparam int C_PGM   = 0;
  localparam int C_ESET  = 1;
  localparam int C_BYP   = 2;
  localparam int C_CHIP  = 3;
  localparam int C_SECT  = 4;
  localparam int C_BX1   = 5;
  localparam int C_BX2   = 6;
  localparam logic [N_CMD*8-1:0] CMD_CODES =
    {8'h00, 8'h90, 8'h30, 8'h10, 8'h20, 8'h80, 8'hA0};

endpackage

// File: rtl/fcd_rst_sync.sv
module fcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
  import fcd_pkg::*;
#(
  parameter int                CMD_AW    = 11,
  parameter logic [CMD_AW-1:0] KEY1_ADDR = 'h555,
  parameter logic [CMD_AW-1:0] KEY2_ADDR = 'h2AA
) (
  input  logic [CMD_AW-1:0] addr_lo,
  input  logic [7:0]        data,
  output logic              key_a,
  output logic              key_b,
  output logic              at_cmd,
  output logic [N_CMD-1:0]  cmd_hit
);

  assign at_cmd = (addr_lo == KEY1_ADDR);
  assign key_a  = at_cmd && (data == KEY_A);
  assign key_b  = (addr_lo == KEY2_ADDR) && (data == KEY_B);

  for (genvar i = 0; i < N_CMD; i++) begin : g_cmd
    assign cmd_hit[i] = (data == CMD_CODES[i*8 +: 8]);
  end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               eng_busy,
  input  logic               key_a,
  input  logic               key_b,
  input  logic               at_cmd,
  input  logic [N_CMD-1:0]   cmd_hit,
  output seq_state_e         state_q,
  output fire_e              fire
);

  seq_state_e state_d;
  logic       accept;

  assign accept = wr_en && !eng_busy;

  always_comb begin
    state_d = state_q;
    fire    = FIRE_NONE;
    if (accept) begin
      case (state_q)
        ST_READ:   state_d = key_a ? ST_UNL1 : ST_READ;
        ST_UNL1:   state_d = key_b ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          if (at_cmd && cmd_hit[C_PGM])       state_d = ST_PGM;
          else if (at_cmd && cmd_hit[C_ESET]) state_d = ST_ESETUP;
          else if (at_cmd && cmd_hit[C_BYP])  state_d = ST_BYP;
          else                                state_d = ST_READ;
        end
        ST_ESETUP: state_d = key_a ? ST_EUNL1 : ST_READ;
        ST_EUNL1:  state_d = key_b ? ST_EUNL2 : ST_READ;
        ST_EUNL2: begin
          state_d = ST_READ;
          if (at_cmd && cmd_hit[C_CHIP])  fire = FIRE_CHIP;
          else if (cmd_hit[C_SECT])       fire = FIRE_SECT;
        end
        ST_PGM: begin
          state_d = ST_READ;
          fire    = FIRE_PGM;
        end
        ST_BYP: begin
          if (cmd_hit[C_PGM])      state_d = ST_BYP_PGM;
          else if (cmd_hit[C_BX1]) state_d = ST_BYP_EXIT;
          else                     state_d = ST_BYP;
        end
        ST_BYP_PGM: begin
          state_d = ST_BYP;
          fire    = FIRE_PGM;
        end
        ST_BYP_EXIT: state_d = cmd_hit[C_BX2] ? ST_READ : ST_BYP;
        default:     state_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ;
    end else if (accept) begin
      state_q <= state_d;
    end
  end

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> $stable(state_q)); // R10

  AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BYP && accept && !cmd_hit[C_BX1])
      |=> (state_q == ST_BYP || state_q == ST_BYP_PGM)); // R7

  AST_BYP_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BYP_EXIT && accept && cmd_hit[C_BX2])
      |=> state_q == ST_READ); // R8

endmodule

// File: rtl/fcd_start_gen.sv
module fcd_start_gen
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fire_e             fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              start_prog,
  output logic              start_chip,
  output logic              start_sect,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  logic addr_en;
  logic data_en;

  assign addr_en = (fire != FIRE_NONE);
  assign data_en = (fire == FIRE_PGM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_prog <= 1'b0;
      start_chip <= 1'b0;
      start_sect <= 1'b0;
    end else begin
      start_prog <= (fire == FIRE_PGM);
      start_chip <= (fire == FIRE_CHIP);
      start_sect <= (fire == FIRE_SECT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr <= '0;
    end else if (addr_en) begin
      op_addr <= wr_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_data <= '0;
    end else if (data_en) begin
      op_data <= wr_data;
    end
  end

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_chip, start_sect})); // R11

  AST_CHIP_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    start_chip |=> !start_chip); // R11

  AST_SECT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    start_sect |=> !start_sect); // R11

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMD_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              eng_busy,
  output logic              start_prog,
  output logic              start_chip,
  output logic              start_sect,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              read_mode,
  output logic              bypass_mode
);

  logic             rst_int_n;
  logic             key_a;
  logic             key_b;
  logic             at_cmd;
  logic [N_CMD-1:0] cmd_hit;
  seq_state_e       state_q;
  fire_e            fire;

  fcd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fcd_cycle_match #(
    .CMD_AW (CMD_AW)
  ) u_match (
    .addr_lo (wr_addr[CMD_AW-1:0]),
    .data    (wr_data),
    .key_a   (key_a),
    .key_b   (key_b),
    .at_cmd  (at_cmd),
    .cmd_hit (cmd_hit)
  );

  fcd_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .eng_busy (eng_busy),
    .key_a    (key_a),
    .key_b    (key_b),
    .at_cmd   (at_cmd),
    .cmd_hit  (cmd_hit),
    .state_q  (state_q),
    .fire     (fire)
  );

  fcd_start_gen #(
    .ADDR_W (ADDR_W)
  ) u_start (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .fire       (fire),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .start_prog (start_prog),
    .start_chip (start_chip),
    .start_sect (start_sect),
    .op_addr    (op_addr),
    .op_data    (op_data)
  );

  assign read_mode   = (state_q == ST_READ);
  assign bypass_mode = (state_q == ST_BYP) || (state_q == ST_BYP_PGM) ||
                       (state_q == ST_BYP_EXIT);

  AST_SECT_ADDR: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_sect |-> op_addr == $past(wr_addr)); // R3

  AST_BYP_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bypass_mode && wr_en) |=> !(start_chip || start_sect)); // R7

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    eng_busy |=> !(start_prog || start_chip || start_sect)); // R10

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [19:0] wr_addr;
  logic [7:0]  wr_data;
  logic        eng_busy;
  logic        start_prog, start_chip, start_sect;
  logic [19:0] op_addr;
  logic [7:0]  op_data;
  logic        read_mode, bypass_mode;

  flash_cmd_decoder #(.ADDR_W(20), .CMD_AW(11)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_busy(eng_busy), .start_prog(start_prog),
    .start_chip(start_chip), .start_sect(start_sect), .op_addr(op_addr),
    .op_data(op_data), .read_mode(read_mode), .bypass_mode(bypass_mode)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference: accepted normal-mode writes kept in queues
  int          qa[$];
  int          qd[$];
  bit          m_byp;
  int          m_bst;
  bit          e_prog, e_chip, e_sect;
  logic [19:0] e_addr;
  logic [7:0]  e_data;

  function automatic bit at(int a, int k);
    return (a & 'h7FF) == k;
  endfunction

  task automatic model_clear();
    qa.delete(); qd.delete(); m_byp = 0; m_bst = 0;
    e_prog = 0; e_chip = 0; e_sect = 0;
  endtask

  task automatic model_step(bit we, int a, int d);
    bit ok;
    int k;
    e_prog = 0; e_chip = 0; e_sect = 0;
    if (!we || eng_busy) return;
    if (m_byp) begin
      if (m_bst == 1) begin
        e_prog = 1; e_addr = a[19:0]; e_data = d[7:0]; m_bst = 0;
      end else if (m_bst == 2) begin
        if (d == 'h00) m_byp = 0;
        m_bst = 0;
      end else if (d == 'hA0) m_bst = 1;
      else if (d == 'h90) m_bst = 2;
      return;
    end
    qa.push_back(a); qd.push_back(d);
    k = qa.size() - 1;
    ok = 0;
    case (k)
      0, 3: begin
        if (k == 3 && qd[2] == 'hA0) begin
          e_prog = 1; e_addr = a[19:0]; e_data = d[7:0];
        end else ok = (d == 'hAA) && at(a, 'h555);
      end
      1, 4: ok = (d == 'h55) && at(a, 'h2AA);
      2: begin
        ok = at(a, 'h555) && (d == 'hA0 || d == 'h80 || d == 'h20);
        if (ok && d == 'h20) begin m_byp = 1; ok = 0; end
      end
      default: begin
        if (d == 'h10 && at(a, 'h555)) e_chip = 1;
        else if (d == 'h30) begin e_sect = 1; e_addr = a[19:0]; end
      end
    endcase
    if (!ok) begin qa.delete(); qd.delete(); end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "read_mode", read_mode, !m_byp && qa.size() == 0);
    chk(tag, "bypass_mode", bypass_mode, m_byp);
    chk(tag, "start_prog", start_prog, e_prog);
    chk(tag, "start_chip", start_chip, e_chip);
    chk(tag, "start_sect", start_sect, e_sect);
    if (e_prog || e_sect) chk(tag, "op_addr", op_addr, e_addr);
    if (e_prog) chk(tag, "op_data", op_data, e_data);
  endtask

  task automatic wr(int a, int d, string tag);
    wr_en = 1'b1; wr_addr = a[19:0]; wr_data = d[7:0];
    model_step(1'b1, a, d);
    @(negedge clk);
    compare(tag);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b0;
      model_step(1'b0, 0, 0);
      @(negedge clk);
      compare(tag);
    end
  endtask

  task automatic do_reset(string tag);
    rst_n = 1'b0;
    model_clear();
    #1;
    compare(tag);
    @(negedge clk);
    compare(tag);
    rst_n = 1'b1;
    idle(3, tag);
  endtask

  task automatic unlock(string tag);
    wr('h3F555, 'hAA, tag);
    wr('h012AA, 'h55, tag);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; eng_busy = 1'b0;
    model_clear();
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    idle(4, "R1");

    // chip erase, high address bits set on command writes
    unlock("R2"); wr('hAA555, 'h80, "R2"); unlock("R2"); wr('h55555, 'h10, "R2");
    idle(2, "R11");

    // sector erase at arbitrary address
    unlock("R3"); wr('h00555, 'h80, "R3"); unlock("R3"); wr('hAB123, 'h30, "R3");
    idle(2, "R11");

    // normal program
    unlock("R4"); wr('h00555, 'hA0, "R4"); wr('h12345, 'h5A, "R4");
    idle(2, "R4");

    // corrupted sequences
    wr('h00556, 'hAA, "R9"); idle(1, "R9");
    wr('h00555, 'hAA, "R9"); wr('h00123, 'h55, "R9"); idle(1, "R9");
    unlock("R9"); wr('h00555, 'h77, "R9"); idle(1, "R9");
    unlock("R9"); wr('h00555, 'h80, "R9"); wr('h00555, 'hAA, "R9");
    wr('h002AA, 'h56, "R9"); idle(1, "R9");
    unlock("R9"); wr('h00555, 'h80, "R9"); unlock("R9"); wr('h00123, 'h10, "R9");
    idle(1, "R9");
    unlock("R9"); wr('h00555, 'h80, "R9"); unlock("R9"); wr('h00555, 'h44, "R9");
    idle(1, "R9");

    // busy drops writes and holds position
    wr('h00555, 'hAA, "R10");
    eng_busy = 1'b1;
    wr('h002AA, 'h55, "R10"); wr('h00555, 'hAA, "R10"); wr('h00555, 'h10, "R10");
    eng_busy = 1'b0;
    wr('h002AA, 'h55, "R10"); wr('h00555, 'h80, "R10"); unlock("R10");
    eng_busy = 1'b1;
    wr('h00555, 'h10, "R10"); idle(1, "R10");
    eng_busy = 1'b0;
    wr('h00555, 'h10, "R10"); idle(1, "R10");

    // bypass mode
    unlock("R5"); wr('h00555, 'h20, "R5"); idle(1, "R5");
    wr('h00555, 'hAA, "R7"); wr('h002AA, 'h55, "R7"); wr('h00555, 'h80, "R7");
    wr('h00555, 'h10, "R7"); wr('h12000, 'h30, "R7"); idle(1, "R7");
    wr('hFFFFF, 'hA0, "R6"); wr('h54321, 'hC3, "R6"); idle(1, "R6");
    wr('h00000, 'hA0, "R6"); wr('h00001, 'h00, "R6"); idle(1, "R6");
    wr('h00777, 'h90, "R7"); wr('h00777, 'h55, "R7"); idle(1, "R7");
    eng_busy = 1'b1;
    wr('h00000, 'hA0, "R10"); wr('h00010, 'h11, "R10");
    eng_busy = 1'b0;
    idle(1, "R10");
    wr('h3A5A5, 'h90, "R8"); wr('h01234, 'h00, "R8"); idle(1, "R8");
    wr('h12345, 'hA0, "R8"); idle(1, "R8");

    // reset mid-sequence and in bypass
    unlock("R12"); wr('h00555, 'h80, "R12");
    do_reset("R12");
    unlock("R12"); wr('h00555, 'h20, "R12");
    do_reset("R12");
    unlock("R12"); wr('h00555, 'hA0, "R12"); wr('h00042, 'h24, "R12");
    idle(2, "R12");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule